// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Controller

This controller brings an asynchronous DRAM out of power-up and keeps it refreshed afterwards. After reset it keeps every strobe inactive for a programmable start-up pause. It then asks the access sequencer for the memory bus and runs a fixed burst of dummy CAS-before-RAS refresh cycles. When that burst completes, it raises `init_done`.

From then on, an interval counter marks a refresh as owed once per refresh interval. The interval is the retention period divided by the number of rows, expressed in clock cycles. Owed refreshes accumulate while the sequencer withholds the bus. When the bus is granted, they are worked off back to back, and the request is released only after the last precharge. Because every refresh lowers CAS before RAS, the DRAM supplies the row itself and no row address is produced. Address, output enable and data are left to the sequencer.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While `rst_n` is low, `bus_req`, `init_done`, `refresh_active` and `overflow` are 0, and `ras_n`, `cas_n` and `we_n` are 1.
- R2: After reset is released, `bus_req` stays 0 and `ras_n`/`cas_n` stay 1 for exactly STARTUP_CYCLES clock cycles. `bus_req` rises on the next cycle.
- R3: After the pause, DUMMY_COUNT refreshes are run. `init_done` rises in the cycle that follows the last precharge cycle of the final dummy refresh and then stays 1.
- R4: Each refresh has three phases. First, `cas_n` is 0 with `ras_n` 1 for CSR_CYC cycles. Next, both are 0 for RAS_CYC cycles. Last, both are 1 for RP_CYC precharge cycles. `we_n` is 1 in every cycle.
- R5: A refresh starts only in the cycle after `bus_grant` is seen high while a refresh is owed. Without a grant, `ras_n` and `cas_n` stay 1 even while `bus_req` is 1.
- R6: Once `init_done` is 1, one refresh becomes owed every INTERVAL_CYCLES cycles. With no grant, `bus_req` rises exactly INTERVAL_CYCLES cycles after `init_done` rose.
- R7: Up to MAX_PENDING owed refreshes are held. A further one arriving while MAX_PENDING are held sets `overflow`, which then stays 1. A later grant services exactly MAX_PENDING refreshes.
- R8: `bus_req` stays 1 from the first owed refresh until the last precharge cycle of the burst has passed, and falls on the next cycle. `refresh_active` is 1 exactly during the three refresh phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_grant | input | 1 | Bus granted by the access sequencer |
| bus_req | output | 1 | Bus wanted for refresh work |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held inactive |
| init_done | output | 1 | Start-up pause and dummy burst complete |
| refresh_active | output | 1 | A refresh cycle is on the bus |
| overflow | output | 1 | Sticky: an owed refresh was lost |

## Verification
Every output is decoded from registered state, so each result appears in the cycle after the clock edge that caused it. The one exception is `bus_req`: it rises in the same cycle that the owed count becomes non-zero. After a grant, the first low `cas_n` appears one edge later. One refresh then takes CSR_CYC+RAS_CYC+RP_CYC edges, plus one idle cycle before the next refresh. The bench counts edges from each stimulus and samples on the falling clock edge at the predicted cycle. It also samples one cycle earlier, so that a transition one cycle early or late is caught.

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int STARTUP_CYCLES  = 10001,
  parameter int INTERVAL_CYCLES = 1560,
  parameter int DUMMY_COUNT     = 8,
  parameter int MAX_PENDING     = 8,
  parameter int CSR_CYC         = 1,
  parameter int RAS_CYC         = 5,
  parameter int RP_CYC          = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_grant,
  output logic bus_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic init_done,
  output logic refresh_active,
  output logic overflow
);

  localparam int T_A  = (STARTUP_CYCLES > RAS_CYC) ? STARTUP_CYCLES : RAS_CYC;
  localparam int T_B  = (RP_CYC > CSR_CYC) ? RP_CYC : CSR_CYC;
  localparam int TMAX = (T_A > T_B) ? T_A : T_B;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(INTERVAL_CYCLES);
  localparam int PMAX = (MAX_PENDING > DUMMY_COUNT) ? MAX_PENDING : DUMMY_COUNT;
  localparam int PW   = $clog2(PMAX + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_CSR, S_RAS, S_PRE} state_t;

  state_t          state;
  logic [TW-1:0]   tmr;
  logic [IW-1:0]   ivl;
  logic [PW-1:0]   pend;

  wire tmr_done = (tmr == '0);
  wire tick     = init_done && (ivl == IW'(INTERVAL_CYCLES - 1));
  wire retire   = (state == S_PRE) && tmr_done;
  wire start    = (state == S_IDLE) && (pend != '0) && bus_grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_PAUSE;
      tmr   <= TW'(STARTUP_CYCLES - 1);
    end else begin
      case (state)
        S_PAUSE: if (tmr_done) state <= S_IDLE; else tmr <= tmr - 1'b1;
        S_IDLE: if (start) begin
          state <= S_CSR;
          tmr   <= TW'(CSR_CYC - 1);
        end
        S_CSR: if (tmr_done) begin
          state <= S_RAS;
          tmr   <= TW'(RAS_CYC - 1);
        end else tmr <= tmr - 1'b1;
        S_RAS: if (tmr_done) begin
          state <= S_PRE;
          tmr   <= TW'(RP_CYC - 1);
        end else tmr <= tmr - 1'b1;
        S_PRE: if (tmr_done) state <= S_IDLE; else tmr <= tmr - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      overflow  <= 1'b0;
      init_done <= 1'b0;
    end else begin
      if (state == S_PAUSE && tmr_done) begin
        pend <= PW'(DUMMY_COUNT);
      end else begin
        case ({tick, retire})
          2'b10: if (pend == PW'(MAX_PENDING)) overflow <= 1'b1;
                 else pend <= pend + 1'b1;
          2'b01: pend <= pend - 1'b1;
          default: ;
        endcase
      end
      if (retire && pend == PW'(1)) init_done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !init_done || tick) ivl <= '0;
    else                              ivl <= ivl + 1'b1;
  end

  assign ras_n          = (state != S_RAS);
  assign cas_n          = !(state == S_CSR || state == S_RAS);
  assign we_n           = 1'b1;
  assign refresh_active = (state == S_CSR) || (state == S_RAS) || (state == S_PRE);
  assign bus_req        = refresh_active || (state == S_IDLE && pend != '0);

endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
  parameter int RAS_CYC = 5
) (
  input logic clk,
  input logic rst_n,
  input logic bus_grant,
  input logic bus_req,
  input logic ras_n,
  input logic cas_n,
  input logic init_done,
  input logic refresh_active,
  input logic overflow
);

  logic [15:0] ras_low;

  always_ff @(posedge clk) begin
    if (!rst_n || ras_n) ras_low <= '0;
    else                 ras_low <= ras_low + 1'b1;
  end

  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  assert_cas_covers_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_low == 16'(RAS_CYC)));

  assert_needs_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(bus_grant));

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && !bus_req) |-> (ras_n && cas_n));

  assert_init_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_active |-> bus_req);

endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(.RAS_CYC(RAS_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .bus_req(bus_req),
  .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done),
  .refresh_active(refresh_active), .overflow(overflow)
);

// File: tb/dram_refresh_ctrl_bench.sv
module dram_refresh_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STARTUP    = 20;
  localparam int INTERVAL   = 100;
  localparam int NDUMMY     = 8;
  localparam int NPEND      = 8;
  localparam int RCYC       = 10;
  // per-cycle {ras_n, cas_n, refresh_active}: CSR, RAS x5, PRE x3, idle
  localparam logic [2:0] SHAPE [RCYC] = '{3'b101, 3'b001, 3'b001, 3'b001, 3'b001,
                                          3'b001, 3'b111, 3'b111, 3'b111, 3'b110};

  logic clk = 1'b0, rst_n = 1'b0, bus_grant = 1'b0;
  logic bus_req, ras_n, cas_n, we_n, init_done, refresh_active, overflow;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_ctrl #(.STARTUP_CYCLES(STARTUP), .INTERVAL_CYCLES(INTERVAL),
    .DUMMY_COUNT(NDUMMY), .MAX_PENDING(NPEND)) u_dram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .bus_req(bus_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done),
    .refresh_active(refresh_active), .overflow(overflow));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int bad;
    int falls;
    logic prev;
    repeat (3) @(negedge clk);
    check("R1 strobes", {29'd0, ras_n, cas_n, we_n}, 32'h7);
    check("R1 flags", {28'd0, bus_req, init_done, refresh_active, overflow}, 32'h0);

    rst_n = 1'b1;
    bad = 0;
    for (int i = 1; i < STARTUP; i++) begin
      @(negedge clk);
      if (!ras_n || !cas_n || bus_req) bad++;
    end
    check("R2 quiet pause", bad, 0);
    check("R2 req low at end of pause", bus_req, 1'b0);
    @(negedge clk);
    check("R2 req after pause", bus_req, 1'b1);

    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!ras_n || !cas_n || !bus_req) bad++;
    end
    check("R5 no strobes without grant", bad, 0);

    bus_grant = 1'b1;
    for (int n = 1; n <= NDUMMY * RCYC; n++) begin
      int p;
      @(negedge clk);
      p = (n - 1) % RCYC;
      check("R4 refresh shape", {29'd0, ras_n, cas_n, refresh_active}, {29'd0, SHAPE[p]});
      check("R4 we_n high", we_n, 1'b1);
      if (n == NDUMMY * RCYC - 1) check("R3 init not yet", init_done, 1'b0);
      if (p == RCYC - 1 && n < NDUMMY * RCYC) check("R8 req held in burst", bus_req, 1'b1);
    end
    check("R3 init_done after dummies", init_done, 1'b1);
    check("R8 req released", bus_req, 1'b0);

    bus_grant = 1'b0;
    repeat (INTERVAL - 1) @(negedge clk);
    check("R6 no request before interval", bus_req, 1'b0);
    @(negedge clk);
    check("R6 request at interval", bus_req, 1'b1);

    bad = 0;
    for (int i = 1; i < NPEND * INTERVAL; i++) begin
      @(negedge clk);
      if (!ras_n || !cas_n) bad++;
    end
    check("R5 idle while owed", bad, 0);
    check("R7 no overflow at limit", overflow, 1'b0);
    @(negedge clk);
    check("R7 overflow on extra", overflow, 1'b1);

    bus_grant = 1'b1;
    falls = 0;
    prev = 1'b1;
    for (int n = 1; n <= NPEND * RCYC; n++) begin
      @(negedge clk);
      if (prev && !ras_n) falls++;
      prev = ras_n;
      if (n == NPEND * RCYC - 1) check("R8 req until last precharge", bus_req, 1'b1);
    end
    check("R8 req dropped after burst", bus_req, 1'b0);
    check("R7 serviced count", falls, NPEND);
    check("R7 overflow sticky", overflow, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 inactive when idle", refresh_active, 1'b0);
    finish_run();
  end
endmodule